// File: doc/BRIEF.md
# Frame-Locked Three-Channel Pixel Reader

This block streams pixels for three colour channels out of on-chip image stores, each holding a set of still pictures. A picture number comes in from a control register, but the block only adopts it on the frame boundary pulse. Because of this, the displayed picture can only switch between frames, never part-way through one. A pixel counter steps once per pixel strobe and forms the low address bits. The adopted picture number forms the high address bits. Each channel's read word passes through an output register on its way to a DAC. During blanking, the value entering that register is forced to zero.

The block runs on a single system clock. The pixel clock arrives as a one-cycle strobe (`pix_tick`), and the frame boundary arrives as an active-low qualifier sampled on that strobe. A synchronous write port per channel lets the surrounding logic, or a bench, fill the stores. The intended configuration is 11 pixel bits and 8 picture bits. The defaults are smaller so that elaboration stays cheap.

Top module: `pixrd_top`

## Requirements
- R1: Each of the NUM_CH channels reads its own store at address {frame_sel, pix_idx}, with the picture number above the PIX_W pixel bits; channel i drives bits [i*DATA_W +: DATA_W] of `pix_out` (channel 0 = red in the low byte).
- R2: On a pixel strobe with `frame_rst_n` high, the pixel counter increments by one and wraps modulo 2^PIX_W.
- R3: On a pixel strobe with `frame_rst_n` low, the pixel counter returns to 0.
- R4: The selected picture number takes the value of `frame_req` only on a pixel strobe with `frame_rst_n` low; changes of `frame_req` at any other time do not affect the pixels read.
- R5: On a pixel strobe with `blank` low, the output register of each channel captures that channel's store word at the address held before the strobe; the word is visible from the following cycle.
- R6: On a pixel strobe with `blank` high, every channel's output register captures zero.
- R7: In a cycle without a pixel strobe, `pix_out` holds its value.
- R8: Reset sets the selected picture to 0, the pixel counter to 0 and `pix_out` to 0, whatever `frame_req` is.
- R9: `wr_en[i]` high writes `wr_data` into channel i's store at `wr_addr` on the clock edge; later reads of that address return the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_tick | input | 1 | One-cycle pixel strobe |
| frame_rst_n | input | 1 | Frame boundary qualifier, active low, sampled with `pix_tick` |
| blank | input | 1 | Blanking, sampled with `pix_tick` |
| frame_req | input | FRAME_W | Requested picture number |
| wr_en | input | NUM_CH | Per-channel store write enable |
| wr_addr | input | FRAME_W+PIX_W | Store write address {picture, pixel} |
| wr_data | input | DATA_W | Store write data |
| pix_out | output | NUM_CH*DATA_W | Registered channel words for the DACs |

## Verification
The bench builds the block with its defaults: 6 pixel bits, 3 picture bits, 8-bit data and three channels. A frame is then 64 strobes long. This makes counter wrap-around, switching to the top picture number, and every store location reachable in a short run. Each store location holds a word that depends on channel, picture and pixel. As a result, a wrong picture, a wrong pixel index or a swapped channel each show up as a data mismatch at the outputs. The picture request is moved mid-frame to show that the selection waits for the boundary.

// File: rtl/pixrd_pkg.sv
package pixrd_pkg;

    localparam int DEF_PIX_W   = 6;
    localparam int DEF_FRAME_W = 3;
    localparam int DEF_DATA_W  = 8;
    localparam int DEF_NUM_CH  = 3;

    // Per-cycle control view of the pixel timing inputs.
    typedef struct packed {
        logic tick;        // pixel strobe
        logic frame_edge;  // frame boundary on this strobe
        logic blank;       // force channel data to zero
    } pix_ctl_t;

    function automatic pix_ctl_t make_ctl(input logic tick, input logic rst_n, input logic blk);
        pix_ctl_t c;
        c.tick       = tick;
        c.frame_edge = ~rst_n;
        c.blank      = blk;
        return c;
    endfunction

endpackage

// File: rtl/pixrd_addr_gen.sv
module pixrd_addr_gen
    import pixrd_pkg::*;
#(
    parameter int PIX_W   = DEF_PIX_W,
    parameter int FRAME_W = DEF_FRAME_W
) (
    input  logic               clk,
    input  logic               rst,
    input  pix_ctl_t           ctl,
    input  logic [FRAME_W-1:0] frame_req,
    output logic [PIX_W-1:0]   pix_idx,
    output logic [FRAME_W-1:0] frame_sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_idx   <= '0;
            frame_sel <= '0;
        end else if (ctl.tick) begin
            if (ctl.frame_edge) begin
                pix_idx   <= '0;
                frame_sel <= frame_req;
            end else begin
                pix_idx   <= pix_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pixrd_chan_mem.sv
module pixrd_chan_mem
    import pixrd_pkg::*;
#(
    parameter int ADDR_W = DEF_FRAME_W + DEF_PIX_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  pix_ctl_t          ctl,
    output logic [DATA_W-1:0] pix_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_bus;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Blanking pulls the read bus low instead of gating downstream.
    always_comb begin
        rd_bus = ctl.blank ? '0 : store[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= '0;
        end else if (ctl.tick) begin
            pix_q <= rd_bus;
        end
    end

endmodule

// File: rtl/pixrd_top.sv
module pixrd_top
    import pixrd_pkg::*;
#(
    parameter int PIX_W   = DEF_PIX_W,
    parameter int FRAME_W = DEF_FRAME_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int NUM_CH  = DEF_NUM_CH,
    localparam int ADDR_W = FRAME_W + PIX_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pix_tick,
    input  logic                     frame_rst_n,
    input  logic                     blank,
    input  logic [FRAME_W-1:0]       frame_req,
    input  logic [NUM_CH-1:0]        wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*DATA_W-1:0] pix_out
);

    pix_ctl_t           ctl;
    logic [PIX_W-1:0]   pix_idx;
    logic [FRAME_W-1:0] frame_sel;
    logic [ADDR_W-1:0]  rd_addr;

    assign ctl     = make_ctl(pix_tick, frame_rst_n, blank);
    assign rd_addr = {frame_sel, pix_idx};

    pixrd_addr_gen #(
        .PIX_W   (PIX_W),
        .FRAME_W (FRAME_W)
    ) u_addr (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .frame_req (frame_req),
        .pix_idx   (pix_idx),
        .frame_sel (frame_sel)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        pixrd_chan_mem #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_mem (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en[ch]),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_addr (rd_addr),
            .ctl     (ctl),
            .pix_q   (pix_out[ch*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/pixrd_chk.sv
module pixrd_chk #(
    parameter int PIX_W   = 6,
    parameter int FRAME_W = 3,
    parameter int DATA_W  = 8,
    parameter int NUM_CH  = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     pix_tick,
    input logic                     frame_rst_n,
    input logic                     blank,
    input logic [FRAME_W-1:0]       frame_req,
    input logic [PIX_W-1:0]         pix_idx,
    input logic [FRAME_W-1:0]       frame_sel,
    input logic [NUM_CH*DATA_W-1:0] pix_out
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && frame_rst_n) |=> pix_idx == PIX_W'($past(pix_idx) + 1'b1)); // R2

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && !frame_rst_n) |=> pix_idx == '0); // R3

    AST_FRAME_LOAD: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && !frame_rst_n) |=> frame_sel == $past(frame_req)); // R4

    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(pix_tick && !frame_rst_n) |=> $stable(frame_sel)); // R4

    AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && blank) |=> pix_out == '0); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pix_tick |=> $stable(pix_out)); // R7

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (frame_sel == '0 && pix_idx == '0 && pix_out == '0)); // R8

endmodule

bind pixrd_top pixrd_chk #(
    .PIX_W   (PIX_W),
    .FRAME_W (FRAME_W),
    .DATA_W  (DATA_W),
    .NUM_CH  (NUM_CH)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_tick    (pix_tick),
    .frame_rst_n (frame_rst_n),
    .blank       (blank),
    .frame_req   (frame_req),
    .pix_idx     (pix_idx),
    .frame_sel   (frame_sel),
    .pix_out     (pix_out)
);

// File: tb/tb_pixrd_top.sv
module tb_pixrd_top;

    localparam int CLK_P   = 10;
    localparam int PIX_W   = 6;
    localparam int FRAME_W = 3;
    localparam int DATA_W  = 8;
    localparam int NUM_CH  = 3;
    localparam int ADDR_W  = FRAME_W + PIX_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int OUT_W   = NUM_CH * DATA_W;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pix_tick = 1'b0;
    logic               frame_rst_n = 1'b1;
    logic               blank = 1'b0;
    logic [FRAME_W-1:0] frame_req = '0;
    logic [NUM_CH-1:0]  wr_en = '0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic [DATA_W-1:0]  wr_data = '0;
    logic [OUT_W-1:0]   pix_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model state
    logic [DATA_W-1:0]  mem_m [NUM_CH][DEPTH];
    logic [FRAME_W-1:0] m_frame = '0;
    logic [PIX_W-1:0]   m_cnt = '0;
    logic [OUT_W-1:0]   m_out = '0;

    logic [OUT_W-1:0] exp_q [$];
    string            tag_q [$];

    always #(CLK_P/2) clk = ~clk;

    pixrd_top #(
        .PIX_W   (PIX_W),
        .FRAME_W (FRAME_W),
        .DATA_W  (DATA_W),
        .NUM_CH  (NUM_CH)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .pix_tick    (pix_tick),
        .frame_rst_n (frame_rst_n),
        .blank       (blank),
        .frame_req   (frame_req),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pix_out     (pix_out)
    );

    function automatic logic [DATA_W-1:0] pattern(input int ch, input int f, input int p);
        return DATA_W'(ch * 83 + f * 29 + p * 5 + 7);
    endfunction

    task automatic check(input string tag, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic mem_write(input int ch, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en        = '0;
        wr_en[ch]    = 1'b1;
        wr_addr      = a;
        wr_data      = d;
        mem_m[ch][a] = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = '0;
    endtask

    // Driver: applies one cycle of timing inputs and queues the expected output.
    task automatic step(input bit pe, input bit frn, input bit bl, input string tag);
        @(negedge clk);
        pix_tick    = pe;
        frame_rst_n = frn;
        blank       = bl;
        if (pe) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                m_out[ch*DATA_W +: DATA_W] = bl ? '0 : mem_m[ch][{m_frame, m_cnt}];
            end
            if (!frn) begin
                m_cnt   = '0;
                m_frame = frame_req;
            end else begin
                m_cnt = m_cnt + 1'b1;
            end
        end
        exp_q.push_back(m_out);
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    task automatic frame_edge();
        step(1'b1, 1'b0, 1'b1, "R3");
    endtask

    // Monitor: compares each queued expectation a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                check(tag_q.pop_front(), pix_out, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        frame_req = 3'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #(CLK_P/4);
        check("R8", pix_out, '0);

        // Preload every store location (R9 write path, R1 per-channel content).
        for (int ch = 0; ch < NUM_CH; ch++)
            for (int f = 0; f < (1 << FRAME_W); f++)
                for (int p = 0; p < (1 << PIX_W); p++)
                    mem_write(ch, ADDR_W'((f << PIX_W) | p), pattern(ch, f, p));
        check("R8", pix_out, '0);

        // Before any frame edge the picture must still be 0 although req is 5.
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, "R8");

        // Frame edge adopts 5; request moves mid-frame and must be ignored.
        frame_edge();
        for (int i = 0; i < 64; i++) begin
            if (i == 20) frame_req = 3'd2;
            if (i % 9 == 4)       step(1'b0, 1'b1, 1'b0, "R7");
            else if (i % 7 == 3)  step(1'b1, 1'b1, 1'b1, "R6");
            else if (i > 20)      step(1'b1, 1'b1, 1'b0, "R4");
            else                  step(1'b1, 1'b1, 1'b0, "R5");
        end

        // Next edge adopts 2; run past the wrap point of the counter.
        frame_edge();
        for (int i = 0; i < 70; i++) step(1'b1, 1'b1, 1'b0, "R2");

        // Top picture number on all channels.
        frame_req = 3'd7;
        frame_edge();
        for (int i = 0; i < 64; i++) step(1'b1, 1'b1, 1'b0, "R1");

        // Rewrite some words of picture 7 and read them back.
        mem_write(1, ADDR_W'((7 << PIX_W) | 3), 8'hA5);
        mem_write(0, ADDR_W'((7 << PIX_W) | 0), 8'h3C);
        mem_write(2, ADDR_W'((7 << PIX_W) | 5), 8'h00);
        frame_edge();
        for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, "R9");

        // Back-to-back frame edges and blanking right after an edge.
        frame_req = 3'd1;
        frame_edge();
        frame_edge();
        step(1'b1, 1'b1, 1'b1, "R6");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0, "R3");

        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule